// File: doc/BRIEF.md
# Timestamped Phase-Accumulator Clock Generator

This block drives a single TTL line with a square wave made from the top bit of a wrapping phase accumulator. The accumulator advances by a frequency tuning word on every I/O clock cycle, so the line toggles at (tuning word / 2^24) times the I/O clock rate. A tuning word that is not a power of two gives the right average rate, but its edges land with up to one cycle of jitter.

Software posts a command that carries a timestamp and a new tuning word. The block holds the command until the shared timestamp counter reaches the stamp. In that cycle it installs the new word and presets the accumulator to half scale, so the line goes high exactly at the command time and the wave starts with a known phase. A tuning word of zero clears the accumulator and parks the line low, from any phase. Only one command can wait at a time, and a newer post replaces one that has not yet fired.

Top module: `ttlclk_gen`

## Requirements
- R1: While reset is high, and after it is released with no command posted, `ttl_o` is 0.
- R2: A posted command changes nothing until the edge at which `now_i` equals its timestamp. The stamp must be greater than the value `now_i` has at the capture edge, which is the edge after `cmd_valid_i` is sampled high.
- R3: Right after the apply edge of a nonzero tuning word, `ttl_o` is 1.
- R4: After the edge at which `now_i` equals T + k, `ttl_o` equals bit 23 of (0x800000 + k × ftw) mod 2^24, where k ≥ 0, T is the apply stamp and ftw is the applied word.
- R5: For a tuning word of the form 2^(24−n), the wave is periodic with period 2^n cycles and is high for exactly half of every period.
- R6: For any nonzero tuning word, the number of rising edges in a window of W cycles after apply is within one of W × ftw / 2^24.
- R7: A tuning word of 0 forces `ttl_o` to 0 right after its apply edge, whether the line was high or low, and holds it at 0 until another command applies.
- R8: A command posted while an earlier one is still waiting replaces it, and the earlier command never takes effect.
- R9: A new nonzero command applied while the line is in its low phase restarts the phase, so `ttl_o` is 1 right after the apply edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | 32 | Shared timestamp counter, in I/O clock cycles |
| cmd_valid_i | input | 1 | Posts a command for one cycle |
| cmd_time_i | input | 32 | Cycle at which the command takes effect |
| cmd_ftw_i | input | 24 | Frequency tuning word to install (0 = stop) |
| ttl_o | output | 1 | Generated clock line (registered accumulator MSB) |

## Verification
A post is captured one edge after `cmd_valid_i` is driven. Its effect appears on `ttl_o` right after the edge at which `now_i` equals the stamp, because the line is the accumulator's top bit and there is no further register. The bench drives `now_i` as a free-running count and samples one time step after each rising edge. At that point it records the counter value used at that edge and compares `ttl_o` with the closed-form phase of R4 at offset k = now − T. For non-power-of-two words the exact-phase check is paired with a rising-edge count over a window that allows a tolerance of one, so that jitter is accepted as R6 permits.

// File: rtl/ttlclk_pkg.sv
package ttlclk_pkg;

  localparam int unsigned ACC_W_DEFAULT = 24;
  localparam int unsigned TS_W_DEFAULT  = 32;

  typedef enum logic {
    SLOT_IDLE  = 1'b0,
    SLOT_ARMED = 1'b1
  } slot_state_e;

endpackage

// File: rtl/ttlclk_cmd_slot.sv
module ttlclk_cmd_slot
  import ttlclk_pkg::*;
#(
  parameter int unsigned TS_W  = TS_W_DEFAULT,
  parameter int unsigned ACC_W = ACC_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  now_i,
  input  logic             in_valid_i,
  input  logic [TS_W-1:0]  in_time_i,
  input  logic [ACC_W-1:0] in_ftw_i,
  output logic             fire_o,
  output logic [ACC_W-1:0] fire_ftw_o
);

  slot_state_e      state_q;
  logic [TS_W-1:0]  time_q;
  logic [ACC_W-1:0] ftw_q;

  // The waiting command fires when the shared counter meets its stamp
  assign fire_o     = (state_q == SLOT_ARMED) && (now_i == time_q);
  assign fire_ftw_o = ftw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_IDLE;
      time_q  <= '0;
      ftw_q   <= '0;
    end else if (in_valid_i) begin
      // A new post always wins over a command still waiting
      state_q <= SLOT_ARMED;
      time_q  <= in_time_i;
      ftw_q   <= in_ftw_i;
    end else if (fire_o) begin
      state_q <= SLOT_IDLE;
    end
  end

  AST_FIRE_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !in_valid_i) |=> (state_q == SLOT_IDLE)); // R2
  AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == SLOT_ARMED && !fire_o && !in_valid_i) |=>
      (state_q == SLOT_ARMED && $stable(time_q) && $stable(ftw_q))); // R2
  AST_NEW_POST_WINS: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> (state_q == SLOT_ARMED && time_q == $past(in_time_i)
                    && ftw_q == $past(in_ftw_i))); // R8

endmodule

// File: rtl/ttlclk_phase_acc.sv
module ttlclk_phase_acc
  import ttlclk_pkg::*;
#(
  parameter int unsigned ACC_W = ACC_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [ACC_W-1:0] load_ftw_i,
  output logic             tick_o
);

  localparam logic [ACC_W-1:0] HALF_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] ftw_q;
  logic [ACC_W-1:0] acc_q;
  logic             load_is_stop;

  assign load_is_stop = (load_ftw_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_q <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      ftw_q <= load_ftw_i;
      // Preset to half scale so the line rises at the apply edge;
      // a stop clears it so the MSB stays low while adding zero
      acc_q <= load_is_stop ? '0 : HALF_SCALE;
    end else begin
      acc_q <= acc_q + ftw_q;
    end
  end

  assign tick_o = acc_q[ACC_W-1];

  AST_LOAD_GOES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (load_i && !load_is_stop) |=> tick_o); // R3
  AST_STOP_GOES_LOW: assert property (@(posedge clk) disable iff (rst)
    (load_i && load_is_stop) |=> !tick_o); // R7
  AST_STOPPED_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (ftw_q == '0) |-> !tick_o); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(ftw_q)); // R4

endmodule

// File: rtl/ttlclk_gen.sv
module ttlclk_gen
  import ttlclk_pkg::*;
#(
  parameter int unsigned TS_W  = TS_W_DEFAULT,
  parameter int unsigned ACC_W = ACC_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  now_i,
  input  logic             cmd_valid_i,
  input  logic [TS_W-1:0]  cmd_time_i,
  input  logic [ACC_W-1:0] cmd_ftw_i,
  output logic             ttl_o
);

  logic             apply;
  logic [ACC_W-1:0] apply_ftw;

  ttlclk_cmd_slot #(
    .TS_W  (TS_W),
    .ACC_W (ACC_W)
  ) i_slot (
    .clk        (clk),
    .rst        (rst),
    .now_i      (now_i),
    .in_valid_i (cmd_valid_i),
    .in_time_i  (cmd_time_i),
    .in_ftw_i   (cmd_ftw_i),
    .fire_o     (apply),
    .fire_ftw_o (apply_ftw)
  );

  ttlclk_phase_acc #(
    .ACC_W (ACC_W)
  ) i_acc (
    .clk        (clk),
    .rst        (rst),
    .load_i     (apply),
    .load_ftw_i (apply_ftw),
    .tick_o     (ttl_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !ttl_o); // R1

endmodule

// File: tb/test_ttlclk_gen.sv
module test_ttlclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W  = 32;
  localparam int ACC_W = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TS_W-1:0]  now_r = '0;
  logic             cmd_valid = 1'b0;
  logic [TS_W-1:0]  cmd_time = '0;
  logic [ACC_W-1:0] cmd_ftw = '0;
  logic             ttl_o;

  int n_chk  = 0;
  int n_fail = 0;

  // model of the currently running wave
  logic [ACC_W-1:0] cur_ftw = '0;
  logic [TS_W-1:0]  cur_t   = '0;
  int rises = 0;
  int highs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) now_r <= now_r + 1;

  ttlclk_gen #(.TS_W(TS_W), .ACC_W(ACC_W)) i_ttlclk_gen (
    .clk         (clk),
    .rst         (rst),
    .now_i       (now_r),
    .cmd_valid_i (cmd_valid),
    .cmd_time_i  (cmd_time),
    .cmd_ftw_i   (cmd_ftw),
    .ttl_o       (ttl_o)
  );

  function automatic logic exp_out(logic [ACC_W-1:0] f, int k);
    logic [63:0] a;
    if (f == '0) return 1'b0;
    a = 64'h800000 + 64'(k) * 64'(f);
    return a[23];
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at now=%0d: ttl_o=%0b expected %0b", req, now_r, act, exp);
    end
  endtask

  task automatic chk_int(input bit ok, input int act, input int exp, input string req);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // advance past one rising edge; now_r then holds the value used at it
  task automatic step();
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic post(input logic [TS_W-1:0] t, input logic [ACC_W-1:0] f);
    cmd_time  = t;
    cmd_ftw   = f;
    cmd_valid = 1'b1;
  endtask

  function automatic logic [TS_W-1:0] find_t(input logic want, input int min_off);
    for (int d = min_off; d < min_off + 64; d++)
      if (exp_out(cur_ftw, int'(now_r + TS_W'(d) - cur_t)) == want)
        return now_r + TS_W'(d);
    return now_r + TS_W'(min_off);
  endfunction

  // run until the new command applies at t, then n_after more cycles
  task automatic run_to(input logic [TS_W-1:0] t, input logic [ACC_W-1:0] f,
                        input int n_after, input string pre_tag,
                        input string apply_tag, input string run_tag);
    logic prev;
    prev = ttl_o;
    rises = 0;
    highs = 0;
    forever begin
      step();
      if (now_r != t) begin
        chk(ttl_o, exp_out(cur_ftw, int'(now_r - cur_t)), pre_tag);
        prev = ttl_o;
      end else break;
    end
    cur_ftw = f;
    cur_t   = t;
    chk(ttl_o, exp_out(f, 0), apply_tag);
    prev = ttl_o;
    for (int k = 1; k <= n_after; k++) begin
      step();
      chk(ttl_o, exp_out(f, k), run_tag);
      if (ttl_o && !prev) rises++;
      if (ttl_o) highs++;
      prev = ttl_o;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(ttl_o, 1'b0, "R1 in reset");
    end
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(ttl_o, 1'b0, "R1 after reset");
    end
  endtask

  task automatic t_start_pow2();
    logic [TS_W-1:0] t;
    t = now_r + 6;
    post(t, 24'h200000);
    run_to(t, 24'h200000, 32, "R2", "R3", "R4");
    chk_int(rises == 4, rises, 4, "R5 rising edges per 32 cycles");
    chk_int(highs == 16, highs, 16, "R5 high cycles per 32 cycles");
  endtask

  task automatic t_restart_low();
    logic [TS_W-1:0] t;
    t = find_t(1'b0, 3);
    post(t, 24'h400000);
    run_to(t, 24'h400000, 16, "R4", "R9", "R4");
    chk_int(rises == 4 && highs == 8, rises, 4, "R5 period 4");
  endtask

  task automatic t_jitter();
    logic [TS_W-1:0] t;
    t = now_r + 3;
    post(t, 24'h300000);
    run_to(t, 24'h300000, 64, "R4", "R3", "R4");
    chk_int(rises >= 11 && rises <= 13, rises, 12, "R6 rising edges in 64 cycles");
  endtask

  task automatic t_stop(input logic phase, input string tag);
    logic [TS_W-1:0] t;
    t = now_r + 3;
    post(t, 24'h100000);
    run_to(t, 24'h100000, 2, "R4", "R3", "R4");
    t = find_t(phase, 3);
    post(t, '0);
    run_to(t, '0, 20, "R4", tag, "R7 stays low");
    chk_int(rises == 0, rises, 0, "R7 no edges after stop");
  endtask

  task automatic t_replace();
    logic [TS_W-1:0] ta;
    logic [TS_W-1:0] tb;
    ta = now_r + 6;
    post(ta, 24'h400000);
    step();
    chk(ttl_o, 1'b0, "R8 before replace");
    step();
    tb = now_r + 12;
    post(tb, 24'h200000);
    run_to(tb, 24'h200000, 8, "R8 old command dropped", "R3", "R4");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    t_reset();
    t_start_pow2();
    t_restart_low();
    t_jitter();
    t_stop(1'b1, "R7 stop from high");
    t_stop(1'b0, "R7 stop from low");
    t_replace();
    finish_run();
  end

endmodule